// File: doc/BRIEF.md
# Conditional bit set/clear unit

This block is the execution stage for byte-wide single-bit writes. Each issued operation brings a short control word, the byte to modify, a register value that may supply the bit number, and the current zero flag. The unit decodes the control word, picks the bit index, decides whether the operation takes effect, and returns the modified byte with a write-enable. The write-enable tells the surrounding datapath whether to store the byte back to its destination. The unit does not read or write registers or memory, and it does not change any flag.

Three operations are supported. Set forces the selected bit to one. Clear forces it to zero. Conditional set forces the bit to one only when the zero flag matches a polarity carried in the control word. The usual destination of a conditional set is a memory location, and a failed condition leaves that location untouched. The bit number comes either from a 3-bit immediate field or from the three low bits of the register value. All outputs are registered and appear one clock after the operation is presented.

Top module: `cond_bit_unit`

## Requirements
- R1: With operation code 2'b00 (set) in ctrl[6:5], the addressed bit of the result is 1 and wr_en is 1, even when that bit was already 1 in the operand.
- R2: With operation code 2'b01 (clear), the addressed bit of the result is 0 and wr_en is 1, even when that bit was already 0.
- R3: When ctrl[3] is 0, the bit number is the immediate field ctrl[2:0].
- R4: When ctrl[3] is 1, the bit number is reg_bitno[2:0], and reg_bitno bits above bit 2 and the immediate field have no effect on the result.
- R5: With operation code 2'b10 (conditional set) and ctrl[4]=1, the set takes place, with wr_en 1, when zf is 1.
- R6: With operation code 2'b10 and ctrl[4]=0, the set takes place, with wr_en 1, when zf is 0.
- R7: When a conditional set's test fails, wr_en is 0 and the result equals the operand unchanged.
- R8: Operation code 2'b11 is a no-operation: wr_en is 0 and the result equals the operand.
- R9: Bits other than the addressed bit always equal the operand's bits.
- R10: The result and wr_en for an operation presented with in_valid high appear with out_valid high one clock later. When no operation was presented, out_valid and wr_en are both 0.
- R11: While rst is high, out_valid, wr_en and result are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| ctrl | input | 7 | Control word: [2:0] immediate bit number, [3] register source, [4] zero-flag polarity, [6:5] operation |
| operand | input | 8 | Byte to modify |
| reg_bitno | input | 32 | Register value whose low three bits may give the bit number |
| zf | input | 1 | Current zero flag |
| out_valid | output | 1 | Result is valid this cycle |
| result | output | 8 | Modified (or unmodified) byte |
| wr_en | output | 1 | Destination must be written |

## Verification
Every result of this block is due exactly one rising edge after the cycle in which in_valid was high. The bench drives inputs on the falling edge and, at the same moment, pushes the expected byte and write-enable into a queue. A monitor samples on the next falling edge, one full edge after the capturing rise. It pops one entry for each cycle with out_valid high and checks that wr_en is low in every cycle without a result. Runs of back-to-back operations and idle gaps both appear, so a result that arrives a cycle early or late misaligns with the queue and is reported.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

  typedef enum logic [1:0] {
    OP_SET  = 2'b00,
    OP_CLR  = 2'b01,
    OP_CSET = 2'b10,
    OP_NONE = 2'b11
  } bit_op_e;

  typedef struct packed {
    bit_op_e op;
    logic    from_reg;
    logic    want_z;
  } bit_ctrl_t;

endpackage

// File: rtl/cbu_decode.sv
module cbu_decode
  import cbu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_W  = 32,
  localparam int IDX_W  = $clog2(DATA_W),
  localparam int CTRL_W = IDX_W + 4
) (
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic [REG_W-1:0]  reg_val,
  output bit_ctrl_t         dec,
  output logic [IDX_W-1:0]  bit_idx
);

  localparam int SRC_POS = IDX_W;
  localparam int POL_POS = IDX_W + 1;
  localparam int OP_LSB  = IDX_W + 2;

  logic unused_reg_hi;

  always_comb begin
    dec.op       = bit_op_e'(ctrl_word[OP_LSB +: 2]);
    dec.from_reg = ctrl_word[SRC_POS];
    dec.want_z   = ctrl_word[POL_POS];
    bit_idx      = dec.from_reg ? reg_val[IDX_W-1:0] : ctrl_word[IDX_W-1:0];
  end

  assign unused_reg_hi = ^reg_val[REG_W-1:IDX_W];

endmodule

// File: rtl/cbu_cond.sv
module cbu_cond
  import cbu_pkg::*;
(
  input  bit_ctrl_t dec,
  input  logic      zf,
  output logic      exec,
  output logic      set_val
);

  always_comb begin
    unique case (dec.op)
      OP_SET:  exec = 1'b1;
      OP_CLR:  exec = 1'b1;
      OP_CSET: exec = (zf == dec.want_z);
      default: exec = 1'b0;
    endcase
    set_val = (dec.op != OP_CLR);
  end

endmodule

// File: rtl/cbu_bitop.sv
module cbu_bitop #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              exec,
  input  logic              set_val,
  output logic [DATA_W-1:0] dout
);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic hit;
    assign hit     = exec && (bit_idx == IDX_W'(i));
    assign dout[i] = hit ? set_val : din[i];
  end

endmodule

// File: rtl/cond_bit_unit.sv
module cond_bit_unit
  import cbu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_W  = 32,
  localparam int IDX_W  = $clog2(DATA_W),
  localparam int CTRL_W = IDX_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [DATA_W-1:0] operand,
  input  logic [REG_W-1:0]  reg_bitno,
  input  logic              zf,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              wr_en
);

  bit_ctrl_t         dec;
  logic [IDX_W-1:0]  bit_idx;
  logic              exec;
  logic              set_val;
  logic [DATA_W-1:0] next_byte;

  cbu_decode #(.DATA_W(DATA_W), .REG_W(REG_W)) u_dec (
    .ctrl_word (ctrl),
    .reg_val   (reg_bitno),
    .dec       (dec),
    .bit_idx   (bit_idx)
  );

  cbu_cond u_cond (
    .dec     (dec),
    .zf      (zf),
    .exec    (exec),
    .set_val (set_val)
  );

  cbu_bitop #(.DATA_W(DATA_W)) u_bit (
    .din     (operand),
    .bit_idx (bit_idx),
    .exec    (exec),
    .set_val (set_val),
    .dout    (next_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid && exec;
      if (in_valid) result <= next_byte;
    end
  end

  AST_SET_FORCES_ONE: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(dec.op) == OP_SET |-> result[$past(bit_idx)] && wr_en); // R1
  AST_CLR_FORCES_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(dec.op) == OP_CLR |-> !result[$past(bit_idx)] && wr_en); // R2
  AST_NOWRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    out_valid && !wr_en |-> result == $past(operand)); // R7
  AST_NONE_NOWRITE: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(dec.op) == OP_NONE |-> !wr_en); // R8
  AST_ONE_BIT_MAX: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones(result ^ $past(operand)) <= 1); // R9
  AST_WR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> out_valid); // R10
  AST_VALID_ONE_LATER: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid) && !$past(rst) |-> out_valid); // R10

endmodule

// File: tb/sim_cond_bit_unit.sv
module sim_cond_bit_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [6:0]  ctrl = '0;
  logic [7:0]  operand = '0;
  logic [31:0] reg_bitno = '0;
  logic        zf = 1'b0;
  logic        out_valid;
  logic [7:0]  result;
  logic        wr_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  cond_bit_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ctrl(ctrl),
    .operand(operand), .reg_bitno(reg_bitno), .zf(zf),
    .out_valid(out_valid), .result(result), .wr_en(wr_en)
  );

  function automatic logic [6:0] mk(logic [1:0] op, logic pol, logic src, logic [2:0] imm);
    return {op, pol, src, imm};
  endfunction

  // Expected {wr_en, result} from the requirements
  function automatic logic [8:0] model(logic [6:0] c, logic [7:0] d, logic [31:0] r, logic z);
    logic [2:0] idx;
    logic [7:0] o;
    logic       w;
    idx = c[3] ? r[2:0] : c[2:0];
    o = d;
    w = 1'b0;
    case (c[6:5])
      2'b00: begin o[idx] = 1'b1; w = 1'b1; end
      2'b01: begin o[idx] = 1'b0; w = 1'b1; end
      2'b10: if (z == c[4]) begin o[idx] = 1'b1; w = 1'b1; end
      default: ;
    endcase
    return {w, o};
  endfunction

  task automatic send(logic [6:0] c, logic [7:0] d, logic [31:0] r, logic z, string tag);
    @(negedge clk);
    ctrl = c; operand = d; reg_bitno = r; zf = z; in_valid = 1'b1;
    exp_q.push_back(model(c, d, r, z));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      ctrl = 7'h7F; operand = 8'h5A; zf = ~zf;
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        logic [8:0] e;
        string t;
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R10: unexpected result %h wr_en %b, expected none", result, wr_en);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if ({wr_en, result} !== e) begin
            errors++;
            $display("FAIL %s: got wr_en=%b result=%h, expected wr_en=%b result=%h",
                     t, wr_en, result, e[8], e[7:0]);
          end
        end
      end else begin
        checks++;
        if (wr_en !== 1'b0) begin
          errors++;
          $display("FAIL R10: wr_en=%b without result, expected 0", wr_en);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({out_valid, wr_en, result} !== 10'b0) begin
      errors++;
      $display("FAIL R11: reset outputs %b%b%h, expected 0 0 00", out_valid, wr_en, result);
    end
    rst = 1'b0;
    idle(2);
    send(mk(2'b00, 0, 0, 3'd0), 8'h00, 32'h0, 1'b0, "R1 R3 set bit0");
    send(mk(2'b00, 0, 0, 3'd7), 8'h80, 32'h0, 1'b1, "R1 set already-one bit7");
    send(mk(2'b01, 0, 0, 3'd3), 8'hFF, 32'h0, 1'b0, "R2 clear bit3");
    idle(1);
    send(mk(2'b01, 1, 0, 3'd5), 8'h00, 32'h0, 1'b1, "R2 clear already-zero bit5");
    send(mk(2'b00, 0, 1, 3'd7), 8'h00, 32'hFFFF_FFFA, 1'b0, "R4 reg bit number 2");
    send(mk(2'b01, 0, 1, 3'd0), 8'hFF, 32'h8000_0006, 1'b0, "R4 reg high bits ignored");
    send(mk(2'b10, 1, 0, 3'd6), 8'h00, 32'h0, 1'b1, "R5 cset on Z=1");
    send(mk(2'b10, 1, 0, 3'd6), 8'h21, 32'h0, 1'b0, "R7 cset Z=1 test fails");
    idle(2);
    send(mk(2'b10, 0, 1, 3'd0), 8'h10, 32'h0000_0101, 1'b0, "R6 cset on Z=0");
    send(mk(2'b10, 0, 0, 3'd4), 8'h0F, 32'h0, 1'b1, "R7 cset Z=0 test fails");
    send(mk(2'b11, 1, 0, 3'd2), 8'h3C, 32'h0, 1'b1, "R8 no-op");
    send(mk(2'b11, 0, 1, 3'd1), 8'hC3, 32'h1, 1'b0, "R8 no-op reg source");
    for (int b = 0; b < 8; b++) begin
      send(mk(2'b00, 0, 0, 3'(b)), 8'hA5, 32'h0, 1'(b), "R9 set sweep");
      send(mk(2'b01, 0, 1, 3'(7 - b)), 8'hA5, 32'(b), 1'(b), "R9 clear sweep");
    end
    idle(4);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10: %0d results missing, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule